// File: doc/BRIEF.md
# Banked Selectable Clock Divider

This block turns one fast source clock into three banks of divided clock outputs: five copies in bank A, four in bank B and two in bank C. Each bank has a one-bit ratio select that picks between two divide ratios. A shared stage can halve the rate at which every bank divider advances. A step mode makes the dividers advance only on rising edges of a separate reference input, so a debugger can walk the outputs one reference edge at a time. Any output edge may then need several reference edges to appear.

A combined hold input clears all divider state and drops the output enable of every bank, which models tri-stating the pads. The dividers share one phase counter, so after release all banks start on the same source edge and stay phase aligned. A select change is stored and applied only when the shared counter passes phase zero. Because of this, no output ever produces a shortened pulse. All inputs are synchronous to the source clock. The reset is synchronous and active high.

Top module: `bank_clkdiv`

## Requirements
- R1: While `rst` or `hold` is high, the output enables are low, every output is low after the next clock edge, and the divider phase and pre-divide state are cleared.
- R2: Bank A divides the tick rate by 4 when `sel_a` is 0 and by 6 when `sel_a` is 1.
- R3: Bank B divides the tick rate by 4 when `sel_b` is 0 and by 2 when `sel_b` is 1.
- R4: Bank C divides the tick rate by 2 when `sel_c` is 0 and by 4 when `sel_c` is 1.
- R5: With `half_sel` at 1, the dividers advance on every second advance event, so every output runs at half the rate it would have with `half_sel` at 0. The first step after release comes on the second event.
- R6: Every output is high for exactly half of each of its periods, the divide-by-6 ratio included (3 ticks high, 3 low).
- R7: On the first tick after `hold` falls, all outputs go high together. Ticks are counted modulo 12, the least common multiple of the ratios, and every output has a rising edge at count 0.
- R8: A change on a ratio select takes effect only at the tick where the shared count is 0 (every 12 ticks). Until then the bank keeps its old ratio.
- R9: With `bypass` at 1, the dividers advance only on a clock edge where `ref_in` is 1 and was 0 at the previous edge. With no such rising edge the outputs stay unchanged.
- R10: All outputs of one bank carry identical values at all times.
- R11: When `rst` and `hold` are both low, all three output enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Clears divider state and disables outputs while high |
| half_sel | input | 1 | Inserts the shared divide-by-2 stage |
| bypass | input | 1 | Step mode: advance on rising edges of `ref_in` only |
| ref_in | input | 1 | Reference used as the advance source in step mode |
| sel_a | input | 1 | Bank A ratio: 0 = /4, 1 = /6 |
| sel_b | input | 1 | Bank B ratio: 0 = /4, 1 = /2 |
| sel_c | input | 1 | Bank C ratio: 0 = /2, 1 = /4 |
| qa | output | 5 | Bank A clock copies |
| qb | output | 4 | Bank B clock copies |
| qc | output | 2 | Bank C clock copies |
| oe_a | output | 1 | Bank A output enable |
| oe_b | output | 1 | Bank B output enable |
| oe_c | output | 1 | Bank C output enable |

## Verification
A wrong shared phase shows up as rising edges that are not aligned across banks, or as a divide-by-6 high time that is not exactly three ticks. Either fault is visible within one 12-tick alignment period after release. A select register that loads too early moves a bank's next edge inside the current period, and the port waveform shows this before the count returns to 0. A pre-divide or step-mode fault changes how many source edges lie between output transitions, so it shows at the very first output step.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    // Greatest common divisor, used only at elaboration time.
    function automatic int gcd_f(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int lcm_f(input int a, input int b);
        return (a / gcd_f(a, b)) * b;
    endfunction

    // Level of a divide-by-div clock at tick count ph (high for the first half).
    function automatic logic level_at(input int ph, input int div);
        return (ph % div) < (div / 2);
    endfunction

    // Timing events shared by all banks.
    typedef struct packed {
        logic tick;   // dividers advance on this edge
        logic align;  // shared count is at phase zero
    } step_t;

endpackage

// File: rtl/tick_gen.sv
module tick_gen (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic half_sel,
    input  logic bypass,
    input  logic ref_in,
    output logic tick
);
    logic ref_q;
    logic pre;
    logic adv;

    // An advance event is every edge, or a reference rising edge in step mode.
    assign adv  = bypass ? (ref_in & ~ref_q) : 1'b1;
    assign tick = adv & (~half_sel | pre);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= 1'b0;
            pre   <= 1'b0;
        end else begin
            ref_q <= ref_in;
            if (hold || !half_sel) begin
                pre <= 1'b0;
            end else if (adv) begin
                pre <= ~pre;
            end
        end
    end
endmodule

// File: rtl/phase_ctr.sv
module phase_ctr #(
    parameter int PERIOD = 12,
    localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          tick,
    output logic [PW-1:0] ph,
    output logic          align
);
    always_ff @(posedge clk) begin
        if (rst || hold) begin
            ph <= '0;
        end else if (tick) begin
            if (ph == PW'(PERIOD - 1)) begin
                ph <= '0;
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    assign align = (ph == '0);
endmodule

// File: rtl/bank_div.sv
module bank_div
    import bcd_pkg::*;
#(
    parameter int DIV_LO = 4,
    parameter int DIV_HI = 6,
    parameter int COPIES = 5,
    parameter int PW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  step_t             step,
    input  logic [PW-1:0]     ph,
    input  logic              sel,
    output logic [COPIES-1:0] q
);
    logic act_sel;
    logic eff_sel;
    logic q_r;
    logic lvl_lo;
    logic lvl_hi;

    // A new select is only taken at phase zero of the shared count.
    assign eff_sel = step.align ? sel : act_sel;
    assign lvl_lo  = level_at(int'(ph), DIV_LO);
    assign lvl_hi  = level_at(int'(ph), DIV_HI);

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            act_sel <= sel;
            q_r     <= 1'b0;
        end else if (step.tick) begin
            q_r <= eff_sel ? lvl_hi : lvl_lo;
            if (step.align) begin
                act_sel <= sel;
            end
        end
    end

    // Every copy in the bank is driven from the one register.
    assign q = {COPIES{q_r}};
endmodule

// File: rtl/bank_clkdiv.sv
module bank_clkdiv
    import bcd_pkg::*;
#(
    parameter int N_A    = 5,
    parameter int N_B    = 4,
    parameter int N_C    = 2,
    parameter int A_LO   = 4,
    parameter int A_HI   = 6,
    parameter int B_LO   = 4,
    parameter int B_HI   = 2,
    parameter int C_LO   = 2,
    parameter int C_HI   = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           hold,
    input  logic           half_sel,
    input  logic           bypass,
    input  logic           ref_in,
    input  logic           sel_a,
    input  logic           sel_b,
    input  logic           sel_c,
    output logic [N_A-1:0] qa,
    output logic [N_B-1:0] qb,
    output logic [N_C-1:0] qc,
    output logic           oe_a,
    output logic           oe_b,
    output logic           oe_c
);
    localparam int PERIOD = lcm_f(lcm_f(lcm_f(A_LO, A_HI), lcm_f(B_LO, B_HI)),
                                  lcm_f(C_LO, C_HI));
    localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic          tick;
    logic [PW-1:0] ph;
    logic          align;
    step_t         step;
    logic          drv_en;

    tick_gen u_tick (
        .clk      (clk),
        .rst      (rst),
        .hold     (hold),
        .half_sel (half_sel),
        .bypass   (bypass),
        .ref_in   (ref_in),
        .tick     (tick)
    );

    phase_ctr #(.PERIOD(PERIOD)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .hold  (hold),
        .tick  (tick),
        .ph    (ph),
        .align (align)
    );

    assign step = '{tick: tick, align: align};

    bank_div #(.DIV_LO(A_LO), .DIV_HI(A_HI), .COPIES(N_A), .PW(PW)) u_bank_a (
        .clk (clk), .rst (rst), .hold (hold), .step (step), .ph (ph),
        .sel (sel_a), .q (qa)
    );

    bank_div #(.DIV_LO(B_LO), .DIV_HI(B_HI), .COPIES(N_B), .PW(PW)) u_bank_b (
        .clk (clk), .rst (rst), .hold (hold), .step (step), .ph (ph),
        .sel (sel_b), .q (qb)
    );

    bank_div #(.DIV_LO(C_LO), .DIV_HI(C_HI), .COPIES(N_C), .PW(PW)) u_bank_c (
        .clk (clk), .rst (rst), .hold (hold), .step (step), .ph (ph),
        .sel (sel_c), .q (qc)
    );

    assign drv_en = ~(rst | hold);
    assign oe_a   = drv_en;
    assign oe_b   = drv_en;
    assign oe_c   = drv_en;
endmodule

// File: rtl/bank_clkdiv_chk.sv
module bank_clkdiv_chk #(
    parameter int NA = 5,
    parameter int NB = 4,
    parameter int NC = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          hold,
    input logic          half_sel,
    input logic          bypass,
    input logic          ref_in,
    input logic [NA-1:0] qa,
    input logic [NB-1:0] qb,
    input logic [NC-1:0] qc
);
    assert_hold_clears_R1: assert property (@(posedge clk) disable iff (rst)
        hold |=> (qa == '0 && qb == '0 && qc == '0));

    assert_first_tick_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        (!hold && $past(hold) && !half_sel && !bypass) |=> (qa[0] && qb[0] && qc[0]));

    assert_prediv_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        (half_sel && !hold && !$stable(qc[0])) |=> $stable(qc[0]));

    assert_bypass_no_step_R9: assert property (@(posedge clk) disable iff (rst)
        (bypass && !hold && !$past(rst) && !(ref_in && !$past(ref_in)))
        |=> ($stable(qa) && $stable(qb) && $stable(qc)));
endmodule

bind bank_clkdiv bank_clkdiv_chk #(.NA(N_A), .NB(N_B), .NC(N_C)) u_chk (.*);

// File: tb/sim_bank_clkdiv.sv
`timescale 1ns/1ps
module sim_bank_clkdiv;
    logic clk = 1'b0;
    logic rst, hold, half_sel, bypass, ref_in, sel_a, sel_b, sel_c;
    logic [4:0] qa;
    logic [3:0] qb;
    logic [1:0] qc;
    logic oe_a, oe_b, oe_c;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bank_clkdiv u0 (
        .clk(clk), .rst(rst), .hold(hold), .half_sel(half_sel), .bypass(bypass),
        .ref_in(ref_in), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
        .qa(qa), .qb(qb), .qc(qc), .oe_a(oe_a), .oe_b(oe_b), .oe_c(oe_c)
    );

    // half, sel_a, sel_b, sel_c, rises A, B, C over 24 edges
    localparam int NV = 5;
    localparam int VEC [NV][7] = '{
        '{0, 0, 0, 0, 6, 6, 12},
        '{0, 1, 1, 1, 4, 12, 6},
        '{1, 0, 1, 0, 3, 6, 6},
        '{1, 1, 0, 1, 2, 3, 3},
        '{0, 1, 0, 0, 4, 6, 12}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic held_cfg(input logic h, input logic a, input logic b, input logic c,
                            input logic byp);
        @(negedge clk);
        hold = 1'b1; half_sel = h; sel_a = a; sel_b = b; sel_c = c; bypass = byp;
        ref_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int ra, rb, rc, ha, hb, hc, cp, mis;
        logic pa, pb, pc;
        rst = 1'b1; hold = 1'b0; half_sel = 1'b0; bypass = 1'b0; ref_in = 1'b0;
        sel_a = 1'b0; sel_b = 1'b0; sel_c = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 oe in reset", {oe_a, oe_b, oe_c}, 0);
        chk("R1 outputs in reset", {qa, qb, qc}, 0);
        rst = 1'b0;

        // Table walk: R2 R3 R4 R5 R6 R10 R11
        for (int v = 0; v < NV; v++) begin
            held_cfg(VEC[v][0][0], VEC[v][1][0], VEC[v][2][0], VEC[v][3][0], 1'b0);
            hold = 1'b0;
            ra = 0; rb = 0; rc = 0; ha = 0; hb = 0; hc = 0; cp = 0;
            pa = 1'b0; pb = 1'b0; pc = 1'b0;
            for (int k = 1; k <= 24; k++) begin
                @(negedge clk);
                if (qa[0] && !pa) ra++;
                if (qb[0] && !pb) rb++;
                if (qc[0] && !pc) rc++;
                ha += int'(qa[0]); hb += int'(qb[0]); hc += int'(qc[0]);
                if (!(qa == 5'h00 || qa == 5'h1f) || !(qb == 4'h0 || qb == 4'hf) ||
                    !(qc == 2'h0 || qc == 2'h3)) cp++;
                pa = qa[0]; pb = qb[0]; pc = qc[0];
            end
            chk($sformatf("R2/R5 bank A rises vec%0d", v), ra, VEC[v][4]);
            chk($sformatf("R3/R5 bank B rises vec%0d", v), rb, VEC[v][5]);
            chk($sformatf("R4/R5 bank C rises vec%0d", v), rc, VEC[v][6]);
            chk($sformatf("R6 duty A vec%0d", v), ha, 12);
            chk($sformatf("R6 duty B vec%0d", v), hb, 12);
            chk($sformatf("R6 duty C vec%0d", v), hc, 12);
            chk($sformatf("R10 bank copies vec%0d", v), cp, 0);
            chk($sformatf("R11 oe released vec%0d", v), {oe_a, oe_b, oe_c}, 7);
        end

        // R7: all banks rise together on the first tick
        held_cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        hold = 1'b0;
        @(negedge clk);
        chk("R7 first tick all high", {qa[0], qb[0], qc[0]}, 7);
        repeat (11) @(negedge clk);
        // after 12 ticks, count 11: /6 low, /4 low, /4 low
        @(negedge clk);
        chk("R7 realign at count 0", {qa[0], qb[0], qc[0]}, 7);

        // R1: hold mid-run
        repeat (2) @(negedge clk);
        hold = 1'b1;
        #1;
        chk("R1 oe drops with hold", {oe_a, oe_b, oe_c}, 0);
        repeat (4) @(negedge clk);
        chk("R1 outputs cleared in hold", {qa, qb, qc}, 0);

        // R8: select change mid-period waits for count 0
        held_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        hold = 1'b0;
        mis = 0;
        for (int k = 1; k <= 24; k++) begin
            @(negedge clk);
            if (k <= 12) begin
                if (qa[0] !== (((k - 1) % 4) < 2)) mis++;
            end else begin
                if (qa[0] !== (((k - 13) % 6) < 3)) mis++;
            end
            if (k == 5) sel_a = 1'b1;
        end
        chk("R8 select applied at alignment", mis, 0);

        // R9: step mode
        held_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        hold = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 no ref edge no step", {qa[0], qb[0], qc[0]}, 0);
        ref_in = 1'b1;
        @(negedge clk);
        chk("R9 one step on ref rise", {qa[0], qb[0], qc[0]}, 7);
        repeat (3) @(negedge clk);
        chk("R9 ref held high no step", {qa[0], qc[0]}, 3);
        ref_in = 1'b0;
        @(negedge clk);
        ref_in = 1'b1;
        @(negedge clk);
        chk("R9 second step C low", int'(qc[0]), 0);
        chk("R9 second step A high", int'(qa[0]), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule